// File: doc/BRIEF.md
# Per-Channel DMA Control Register Bank

This block holds the per-channel control and status bits of a 24-channel DMA engine behind a plain 32-bit register bus. Each channel has four bits: a run enable, a byte-order swap enable, a source-address step-down enable and a sticky flag for a bad descriptor. Software never writes a whole register of these bits at once. Each enable is raised through a "set" address and dropped through a separate "clear" address. The status flags are cleared by writing ones to them. This lets independent software agents touch different channels without a read-modify-write race.

The DMA engine reports every descriptor it fetches on a small event port: the channel index and the three-bit cycle-control code. A code of zero is illegal. The block then latches that channel's status flag and pulls that channel's run enable low in the same clock. Every other channel keeps its state. The enable outputs drive the data-movement logic, which sits outside this block.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, all four per-channel bit vectors are zero and `bus_rdata` is zero.
- R2: A write to byte offset 0x800 sets the swap enable of every channel whose data bit (bit c for channel c) is 1 and leaves the others unchanged. A read of 0x800 returns the swap enables.
- R3: A write to 0x804 clears the swap enable of every channel whose data bit is 1. Zero bits have no effect. Reads of 0x804 return zero.
- R4: Offset 0x810 sets and 0x814 clears the source step-down enables, with the same rules as R2 and R3. A read of 0x810 returns the state and a read of 0x814 returns zero.
- R5: Offset 0x028 sets and 0x02C clears the channel run enables, with the same rules. A read of 0x028 returns the state and a read of 0x02C returns zero.
- R6: A descriptor event (`desc_vld` high) with `desc_ctrl` = 3'b000 and `desc_ch` below 24 sets that channel's status flag. Other codes, and channel indices of 24 or more, change nothing.
- R7: Such an illegal-descriptor event clears the run enable of that channel only. It wins over a software set of the same bit in the same cycle.
- R8: A read of offset 0x050 returns the status flags. A write there clears each flag whose data bit is 1. When a write-one-to-clear and a hardware event hit the same flag in one cycle, the flag stays set.
- R9: Read data bits [31:24] are always zero. A read of an unmapped address (any address other than those above, including misaligned ones such as 0x801) returns zero. A write to an unmapped address changes no state.
- R10: `bus_rdata` is registered. It carries the addressed value in the cycle after `bus_rd` is high and is zero after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| desc_vld | input | 1 | A descriptor was fetched this cycle |
| desc_ch | input | 5 | Channel of the fetched descriptor |
| desc_ctrl | input | 3 | Cycle-control code of the fetched descriptor |
| chan_en | output | 24 | Per-channel run enables |
| swap_en | output | 24 | Per-channel byte-swap enables |
| src_dec_en | output | 24 | Per-channel source step-down enables |

## Verification
The bench drives a write-one-to-clear and an illegal-descriptor event at the same flag in the same cycle. A design that gave the clear priority would lose the error report. It also sets a run enable in the same cycle as that channel's illegal descriptor. A wrong priority there would leave a faulted channel running. The stimulus includes event indices of 24 to 31, misaligned and unmapped addresses, and reads of write-only clear addresses. A decoder that aliased these, or that let a clear register echo state, would corrupt or expose bits. A reference model compares every output on every clock during a long random phase. That phase also catches writes of zero bits that wrongly change state and read data that lingers after the strobe.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH = 24,
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int CCW = 3,
  parameter logic [AW-1:0] OFS_EN_SET   = 12'h028,
  parameter logic [AW-1:0] OFS_EN_CLR   = 12'h02C,
  parameter logic [AW-1:0] OFS_FAULT    = 12'h050,
  parameter logic [AW-1:0] OFS_SWAP_SET = 12'h800,
  parameter logic [AW-1:0] OFS_SWAP_CLR = 12'h804,
  parameter logic [AW-1:0] OFS_DEC_SET  = 12'h810,
  parameter logic [AW-1:0] OFS_DEC_CLR  = 12'h814
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            bus_addr,
  input  logic                     bus_wr,
  input  logic [DW-1:0]            bus_wdata,
  input  logic                     bus_rd,
  output logic [DW-1:0]            bus_rdata,
  input  logic                     desc_vld,
  input  logic [$clog2(NCH)-1:0]   desc_ch,
  input  logic [CCW-1:0]           desc_ctrl,
  output logic [NCH-1:0]           chan_en,
  output logic [NCH-1:0]           swap_en,
  output logic [NCH-1:0]           src_dec_en
);
  localparam int CHW = $clog2(NCH);

  logic [NCH-1:0] fault_q;
  logic [NCH-1:0] en_q, swap_q, dec_q;
  logic [NCH-1:0] wmask, bad_hit;
  logic [NCH-1:0] rd_sel;
  logic [DW-1:0]  rdata_q;

  assign wmask = bus_wdata[NCH-1:0];

  wire wr_en_set   = bus_wr && (bus_addr == OFS_EN_SET);
  wire wr_en_clr   = bus_wr && (bus_addr == OFS_EN_CLR);
  wire wr_fault    = bus_wr && (bus_addr == OFS_FAULT);
  wire wr_swap_set = bus_wr && (bus_addr == OFS_SWAP_SET);
  wire wr_swap_clr = bus_wr && (bus_addr == OFS_SWAP_CLR);
  wire wr_dec_set  = bus_wr && (bus_addr == OFS_DEC_SET);
  wire wr_dec_clr  = bus_wr && (bus_addr == OFS_DEC_CLR);

  wire bad_code = desc_vld && (desc_ctrl == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_hit
    assign bad_hit[c] = bad_code && (desc_ch == CHW'(c));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      swap_q  <= '0;
      dec_q   <= '0;
      fault_q <= '0;
    end else begin
      en_q    <= (en_q | (wr_en_set ? wmask : '0)) & ~(wr_en_clr ? wmask : '0) & ~bad_hit;
      swap_q  <= (swap_q | (wr_swap_set ? wmask : '0)) & ~(wr_swap_clr ? wmask : '0);
      dec_q   <= (dec_q | (wr_dec_set ? wmask : '0)) & ~(wr_dec_clr ? wmask : '0);
      fault_q <= (fault_q & ~(wr_fault ? wmask : '0)) | bad_hit;
    end
  end

  always_comb begin
    rd_sel = '0;
    unique case (bus_addr)
      OFS_EN_SET:   rd_sel = en_q;
      OFS_FAULT:    rd_sel = fault_q;
      OFS_SWAP_SET: rd_sel = swap_q;
      OFS_DEC_SET:  rd_sel = dec_q;
      default:      rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= bus_rd ? DW'(rd_sel) : '0;
  end

  assign bus_rdata  = rdata_q;
  assign chan_en    = en_q;
  assign swap_en    = swap_q;
  assign src_dec_en = dec_q;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NCH = 24,
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int CCW = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [AW-1:0]          bus_addr,
  input logic                   bus_wr,
  input logic [DW-1:0]          bus_wdata,
  input logic                   bus_rd,
  input logic [DW-1:0]          bus_rdata,
  input logic                   desc_vld,
  input logic [$clog2(NCH)-1:0] desc_ch,
  input logic [CCW-1:0]         desc_ctrl,
  input logic [NCH-1:0]         chan_en,
  input logic [NCH-1:0]         swap_en,
  input logic [NCH-1:0]         src_dec_en,
  input logic [NCH-1:0]         fault_flags
);
  wire bad_ev = desc_vld && (desc_ctrl == '0) && (int'(desc_ch) < NCH);
  wire [NCH-1:0] wm = bus_wdata[NCH-1:0];

  p_swap_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h800) |=> ((swap_en & $past(wm)) == $past(wm)));

  p_swap_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h804) |=> ((swap_en & $past(wm)) == '0));

  p_dec_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h814) |=> ((src_dec_en & $past(wm)) == '0));

  p_fault_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ev |=> fault_flags[$past(desc_ch)]);

  p_auto_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ev |=> !chan_en[$past(desc_ch)]);

  p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != 12'h800 && bus_addr != 12'h804 &&
     bus_addr != 12'h810 && bus_addr != 12'h814) |=> ($stable(swap_en) && $stable(src_dec_en)));

  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));

  always @(negedge clk) begin
    if (rst_n) p_rsvd_r9: assert ((bus_rdata >> NCH) == '0);
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH), .AW(AW), .DW(DW), .CCW(CCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .desc_vld(desc_vld), .desc_ch(desc_ch),
  .desc_ctrl(desc_ctrl), .chan_en(chan_en), .swap_en(swap_en), .src_dec_en(src_dec_en),
  .fault_flags(fault_q)
);

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;

  logic        clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        desc_vld = 0;
  logic [4:0]  desc_ch = '0;
  logic [2:0]  desc_ctrl = '0;
  logic [N-1:0] chan_en, swap_en, src_dec_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .desc_vld(desc_vld), .desc_ch(desc_ch),
    .desc_ctrl(desc_ctrl), .chan_en(chan_en), .swap_en(swap_en), .src_dec_en(src_dec_en)
  );

  // behavioural reference model
  bit m_en[N], m_sw[N], m_dc[N], m_fl[N];
  logic [31:0] m_rd;

  function automatic logic [31:0] pack(input bit v[N]);
    logic [31:0] r = '0;
    for (int c = 0; c < N; c++) r[c] = v[c];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < N; c++) begin m_en[c] = 0; m_sw[c] = 0; m_dc[c] = 0; m_fl[c] = 0; end
      m_rd = 0;
    end else begin
      m_rd = 0;
      if (bus_rd) begin
        if (bus_addr == 12'h028) m_rd = pack(m_en);
        else if (bus_addr == 12'h050) m_rd = pack(m_fl);
        else if (bus_addr == 12'h800) m_rd = pack(m_sw);
        else if (bus_addr == 12'h810) m_rd = pack(m_dc);
      end
      if (bus_wr) begin
        for (int c = 0; c < N; c++) begin
          if (bus_wdata[c]) begin
            case (bus_addr)
              12'h028: m_en[c] = 1;
              12'h02C: m_en[c] = 0;
              12'h050: m_fl[c] = 0;
              12'h800: m_sw[c] = 1;
              12'h804: m_sw[c] = 0;
              12'h810: m_dc[c] = 1;
              12'h814: m_dc[c] = 0;
              default: ;
            endcase
          end
        end
      end
      if (desc_vld && desc_ctrl == 0 && desc_ch < N) begin
        m_fl[desc_ch] = 1;
        m_en[desc_ch] = 0;
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(32'(chan_en), pack(m_en), "R5/R7 chan_en vs model");
      chk(32'(swap_en), pack(m_sw), "R2/R3 swap_en vs model");
      chk(32'(src_dec_en), pack(m_dc), "R4 src_dec_en vs model");
      chk(bus_rdata, m_rd, "R10 rdata vs model");
    end
  end

  task automatic cyc(input bit wr, input bit rd, input logic [11:0] a, input logic [31:0] d,
                     input bit dv, input logic [4:0] ch, input logic [2:0] ct);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    desc_vld = dv; desc_ch = ch; desc_ctrl = ct;
  endtask

  task automatic idle(); cyc(0, 0, 12'h000, 0, 0, 0, 3'd1); endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d); cyc(1, 0, a, d, 0, 0, 3'd1); endtask
  task automatic ev(input logic [4:0] ch, input logic [2:0] ct); cyc(0, 0, 0, 0, 1, ch, ct); endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    cyc(0, 1, a, 0, 0, 0, 3'd1);
    idle();
    chk(bus_rdata, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(32'(chan_en | swap_en | src_dec_en), 0, "R1 reset state");
    chk(bus_rdata, 0, "R1 reset rdata");
    rst_n = 1;
    idle();
    rd_chk(12'h050, 0, "R1 fault flags after reset");

    wr(12'h800, 32'h00F00F); idle();
    chk(32'(swap_en), 32'h00F00F, "R2 swap set");
    wr(12'h804, 32'h00000F); idle();
    chk(32'(swap_en), 32'h00F000, "R3 swap clear");
    rd_chk(12'h804, 0, "R3 clear reg reads zero");
    rd_chk(12'h800, 32'h00F000, "R2 swap readback");
    wr(12'h800, 32'hFFFFFFFF); idle();
    rd_chk(12'h800, 32'h00FFFFFF, "R9 reserved bits zero");

    wr(12'h810, 32'h123); wr(12'h814, 32'h3); idle();
    chk(32'(src_dec_en), 32'h120, "R4 step-down set/clear");
    rd_chk(12'h810, 32'h120, "R4 step-down readback");
    rd_chk(12'h814, 0, "R4 clear reg reads zero");

    wr(12'h808, 32'hFFFFFFFF); wr(12'h801, 32'hFFFFFFFF); idle();
    chk(32'(swap_en), 32'hFFFFFF, "R9 unmapped write ignored swap");
    chk(32'(src_dec_en), 32'h120, "R9 unmapped write ignored dec");
    rd_chk(12'h808, 0, "R9 unmapped read zero");
    rd_chk(12'h801, 0, "R9 misaligned read zero");

    wr(12'h028, 32'hFFFFFF); wr(12'h02C, 32'h1); idle();
    chk(32'(chan_en), 32'hFFFFFE, "R5 enable set/clear");
    rd_chk(12'h028, 32'hFFFFFE, "R5 enable readback");
    rd_chk(12'h02C, 0, "R5 clear reg reads zero");

    ev(5'd5, 3'd0); idle();
    chk(32'(chan_en), 32'hFFFFDE, "R7 only channel 5 disabled");
    rd_chk(12'h050, 32'h20, "R6 flag for channel 5");
    ev(5'd6, 3'd3); ev(5'd25, 3'd0); idle();
    chk(32'(chan_en), 32'hFFFFDE, "R6 legal code / out-of-range channel ignored");
    rd_chk(12'h050, 32'h20, "R6 flags unchanged");

    cyc(1, 0, 12'h028, 32'h80, 1, 5'd7, 3'd0); idle();
    chk(32'(chan_en), 32'hFFFF5E, "R7 event beats set");
    rd_chk(12'h050, 32'hA0, "R6 flag for channel 7");

    wr(12'h050, 32'h0); idle();
    rd_chk(12'h050, 32'hA0, "R8 write zero no effect");
    wr(12'h050, 32'h20); idle();
    rd_chk(12'h050, 32'h80, "R8 write one clears");
    cyc(1, 0, 12'h050, 32'h80, 1, 5'd7, 3'd0); idle();
    rd_chk(12'h050, 32'h80, "R8 hardware event beats clear");
    wr(12'h050, 32'h80); idle();
    rd_chk(12'h050, 32'h0, "R8 flag cleared");
    idle();
    chk(bus_rdata, 0, "R10 rdata zero without read");

    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      int k = $urandom_range(0, 9);
      case (k)
        0: a = 12'h028; 1: a = 12'h02C; 2: a = 12'h050; 3: a = 12'h800; 4: a = 12'h804;
        5: a = 12'h810; 6: a = 12'h814; 7: a = 12'h80C; 8: a = 12'h029; default: a = 12'h000;
      endcase
      cyc($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a, $urandom(),
          $urandom_range(0, 2) == 0, 5'($urandom_range(0, 31)), 3'($urandom_range(0, 3)));
    end
    idle(); idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule